// File: doc/BRIEF.md
# Infrared Low-Power Pulse Generator

This block produces the shortened optical transmit pulse of a serial infrared link running in its low-power encoding. The serial transmitter supplies each outgoing bit together with a one-cycle strobe that marks the start of its bit period. For every logic-zero bit the block drives a single high pulse on the infrared transmit line. A logic-one bit leaves the line at its idle low level.

The width of the pulse depends on the mode. In normal infrared mode the pulse lasts three periods of the 16x baud strobe, which is 3/16 of a bit. In low-power mode the width no longer depends on the baud rate. A private divider splits the reference clock by an 8-bit divisor, loaded through a small write port, into a low-power tick. The pulse then lasts exactly three of those ticks. Software picks the divisor so that the tick falls between roughly 1.42 MHz and 2.12 MHz, which gives a pulse of about 1.41 to 2.11 us.

A pulse always starts on the first selected tick after the bit strobe and ends on the third tick after that. Its width is therefore a whole number of tick periods. A new divisor is held back until the tick period that is running ends.

Top module: `irlp_pulse_gen`

## Requirements
- R1: While reset is asserted and after it is released, `ir_tx` is low and the low-power divisor is zero.
- R2: With `sir_en`=1, `sir_lp`=1 and a settled divisor D (1 to 255), a zero bit gives one high pulse on `ir_tx` that lasts exactly 3*D clock cycles.
- R3: While the divisor is zero, no low-power tick occurs, so in low-power mode a zero bit never raises `ir_tx`. This also holds after a zero is written over an earlier nonzero value.
- R4: With `sir_en`=1 and `sir_lp`=0, a zero bit gives one high pulse that lasts exactly three periods of `baud16_tick`.
- R5: A bit strobe with `tx_bit`=1 gives no pulse in either mode.
- R6: While `sir_en`=0, `ir_tx` stays low whatever the values of `sir_lp`, the divisor, the ticks and the bits.
- R7: A pulse rises one clock cycle after the first selected tick (the baud16 strobe when `sir_lp`=0, the low-power tick when `sir_lp`=1) that comes later than the bit strobe. It falls one cycle after the third selected tick that follows.
- R8: A divisor write takes effect only at the next low-power tick boundary. If the divisor changes from D to W during a pulse, the tick period that is running keeps length D and the pulse lasts D+2*W cycles.
- R9: When `sir_en` is cleared during a pulse, `ir_tx` falls on the next clock edge, and no pulse follows unless a new zero bit is strobed after `sir_en` is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_wr_en | input | 1 | Write strobe for the low-power divisor |
| div_wr_data | input | DIV_W (8) | Divisor value to write; zero stops the low-power tick |
| sir_en | input | 1 | Infrared encoding enable |
| sir_lp | input | 1 | Low-power pulse width select (acts only with `sir_en`) |
| baud16_tick | input | 1 | One-cycle strobe at 16 times the baud rate |
| bit_strobe | input | 1 | One-cycle strobe marking the start of a bit period |
| tx_bit | input | 1 | Serial data bit, sampled with `bit_strobe` |
| ir_tx | output | 1 | Infrared transmit pulse, idle low |

## Verification
The output is registered, so a pulse shows at the first sample after the clock edge that sees the opening tick. When the bench places the baud16 strobe `lead` cycles after the bit strobe, the rise is expected at sample `lead`+1 and the width at 3*P samples for baud period P. In low-power mode the tick phase is hidden, so the bench checks the width of exactly 3*D cycles and bounds the rise to at most D+1 samples. Before each such run it waits long enough for any pending divisor to settle. Divisor changes and disables are driven at the sample where the rise is first seen. The expected width D+2*W, or an abort one sample later, follows from the edge at which the write or the clear is seen.

// File: rtl/irlp_pkg.sv
`timescale 1ns/1ps
package irlp_pkg;

  parameter int unsigned IRLP_DIV_W_DEF       = 8;
  parameter int unsigned IRLP_PULSE_TICKS_DEF = 3;
  parameter int unsigned IRLP_SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    SH_IDLE   = 2'd0,
    SH_ARMED  = 2'd1,
    SH_ACTIVE = 2'd2
  } sh_state_e;

endpackage

// File: rtl/irlp_rst_sync.sv
`timescale 1ns/1ps
module irlp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irlp_lp_divider.sv
`timescale 1ns/1ps
module irlp_lp_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_act,
  output logic             lp_tick
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] pend_q;
  logic [DIV_W-1:0] act_q, act_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             act_zero;
  logic             period_end;
  logic             reload;

  // Period ends on the last count of the divisor now in use; the
  // pending value is taken over only there or while the divider idles.
  always_comb begin
    act_zero   = (act_q == '0);
    period_end = !act_zero && (cnt_q == act_q - ONE);
    reload     = act_zero || period_end;
    tick_d     = period_end;
    act_d      = reload ? pend_q : act_q;
    cnt_d      = reload ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (wr_en) begin
      pend_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign div_act = act_q;
  assign lp_tick = tick_q;

endmodule

// File: rtl/irlp_shaper.sv
`timescale 1ns/1ps
module irlp_shaper
  import irlp_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sir_en,
  input  logic sir_lp,
  input  logic lp_tick,
  input  logic baud16_tick,
  input  logic bit_strobe,
  input  logic tx_bit,
  output logic sel_tick,
  output logic ir_tx
);

  localparam int unsigned CW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

  sh_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tx_q, tx_d;
  logic          arm_req;

  always_comb begin
    sel_tick = sir_lp ? lp_tick : baud16_tick;
    arm_req  = bit_strobe && !tx_bit;
    state_d  = state_q;
    cnt_d    = cnt_q;
    if (!sir_en) begin
      state_d = SH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SH_IDLE: begin
          if (arm_req) state_d = SH_ARMED;
        end
        SH_ARMED: begin
          if (sel_tick) begin
            state_d = SH_ACTIVE;
            cnt_d   = '0;
          end
        end
        SH_ACTIVE: begin
          if (sel_tick) begin
            if (cnt_q == LAST) begin
              state_d = arm_req ? SH_ARMED : SH_IDLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        default: begin
          state_d = SH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
    tx_d = (state_d == SH_ACTIVE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      cnt_q   <= '0;
      tx_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_d;
    end
  end

  assign ir_tx = tx_q;

endmodule

// File: rtl/irlp_pulse_gen.sv
`timescale 1ns/1ps
module irlp_pulse_gen
  import irlp_pkg::*;
#(
  parameter int unsigned DIV_W       = IRLP_DIV_W_DEF,
  parameter int unsigned PULSE_TICKS = IRLP_PULSE_TICKS_DEF,
  parameter int unsigned SYNC_STAGES = IRLP_SYNC_STAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr_en,
  input  logic [DIV_W-1:0] div_wr_data,
  input  logic             sir_en,
  input  logic             sir_lp,
  input  logic             baud16_tick,
  input  logic             bit_strobe,
  input  logic             tx_bit,
  output logic             ir_tx
);

  logic             rst_sync_n;
  logic [DIV_W-1:0] div_act;
  logic             lp_tick;
  logic             sel_tick;

  irlp_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irlp_lp_divider #(
    .DIV_W(DIV_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (div_wr_en),
    .wr_data (div_wr_data),
    .div_act (div_act),
    .lp_tick (lp_tick)
  );

  irlp_shaper #(
    .PULSE_TICKS(PULSE_TICKS)
  ) u_shp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sir_en      (sir_en),
    .sir_lp      (sir_lp),
    .lp_tick     (lp_tick),
    .baud16_tick (baud16_tick),
    .bit_strobe  (bit_strobe),
    .tx_bit      (tx_bit),
    .sel_tick    (sel_tick),
    .ir_tx       (ir_tx)
  );

endmodule

// File: rtl/irlp_checker.sv
`timescale 1ns/1ps
module irlp_checker #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sir_en,
  input logic             ir_tx,
  input logic             lp_tick,
  input logic             sel_tick,
  input logic [DIV_W-1:0] div_act
);

  // R6: a disabled encoder keeps the line low from the next edge
  assert_low_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sir_en |=> !ir_tx);

  // R3: a zero divisor never produces a low-power tick
  assert_no_tick_zero_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act == '0) |=> !lp_tick);

  // R8: the divisor in use changes only together with a tick boundary
  assert_div_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((div_act != $past(div_act)) && ($past(div_act) != '0)) |-> lp_tick);

  // R7: a pulse opens only after a selected tick
  assert_rise_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> $past(sel_tick));

  // R4: an enabled pulse closes only after a selected tick
  assert_fall_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ir_tx) && $past(sir_en)) |-> $past(sel_tick));

endmodule

bind irlp_pulse_gen irlp_checker #(
  .DIV_W(DIV_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .sir_en   (sir_en),
  .ir_tx    (ir_tx),
  .lp_tick  (lp_tick),
  .sel_tick (sel_tick),
  .div_act  (div_act)
);

// File: tb/sim_irlp_pulse_gen.sv
`timescale 1ns/1ps
module sim_irlp_pulse_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_wr_en;
  logic [7:0] div_wr_data;
  logic       sir_en;
  logic       sir_lp;
  logic       baud16_tick;
  logic       bit_strobe;
  logic       tx_bit;
  logic       ir_tx;

  int checks   = 0;
  int failures = 0;
  int cur_div  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irlp_pulse_gen u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_wr_en   (div_wr_en),
    .div_wr_data (div_wr_data),
    .sir_en      (sir_en),
    .sir_lp      (sir_lp),
    .baud16_tick (baud16_tick),
    .bit_strobe  (bit_strobe),
    .tx_bit      (tx_bit),
    .ir_tx       (ir_tx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_div(input int v);
    @(negedge clk);
    div_wr_en   = 1'b1;
    div_wr_data = 8'(v);
    @(negedge clk);
    div_wr_en   = 1'b0;
    idle(2 * ((cur_div > v) ? cur_div : v) + 6);
    cur_div = v;
  endtask

  task automatic quiesce();
    @(negedge clk);
    sir_en = 1'b0; baud16_tick = 1'b0; bit_strobe = 1'b0; div_wr_en = 1'b0;
    idle(2);
  endtask

  task automatic launch(input bit b);
    @(negedge clk);
    bit_strobe  = 1'b1;
    tx_bit      = b;
    baud16_tick = 1'b0;
  endtask

  // Samples ir_tx once per cycle after a launch; P>0 drives baud16 every
  // P cycles starting lead cycles after the strobe.
  task automatic observe(input int maxc, input int P, input int lead,
                         input int new_div, input int drop_after,
                         output int rise, output int width);
    bit high_done = 0;
    rise  = -1;
    width = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (ir_tx) begin
        if (rise < 0) rise = i;
        if (!high_done) width++;
      end else if (rise >= 0) begin
        high_done = 1;
      end
      bit_strobe  = 1'b0;
      baud16_tick = (P > 0) && (i >= lead) && (((i - lead) % P) == 0);
      div_wr_en   = (new_div >= 0) && (rise == i);
      div_wr_data = 8'((new_div >= 0) ? new_div : 0);
      if ((drop_after >= 0) && (rise >= 0) && (i == rise + drop_after)) sir_en = 1'b0;
    end
    div_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    int r, w;
    rst_n = 1'b0; div_wr_en = 0; div_wr_data = 0; sir_en = 0; sir_lp = 0;
    baud16_tick = 0; bit_strobe = 0; tx_bit = 1;
    idle(4);
    chk(ir_tx == 1'b0, "R1 during reset", ir_tx, 0);
    rst_n = 1'b1;
    idle(5);
    chk(ir_tx == 1'b0, "R1 after reset", ir_tx, 0);
    // reset divisor is zero: low-power mode must stay silent
    sir_en = 1; sir_lp = 1;
    launch(0);
    observe(300, 0, 0, -1, -1, r, w);
    chk(r < 0, "R1 divisor zero after reset", r, -1);
    quiesce();
  endtask

  task automatic t_zero_div();
    int r, w;
    write_div(3);
    write_div(0);
    sir_en = 1; sir_lp = 1;
    launch(0);
    observe(300, 0, 0, -1, -1, r, w);
    chk(r < 0, "R3 zero divisor no pulse", r, -1);
    quiesce();
  endtask

  task automatic t_lp(input int D);
    int r, w;
    write_div(D);
    sir_en = 1; sir_lp = 1;
    launch(0);
    observe(4 * D + 20, 0, 0, -1, -1, r, w);
    chk(w == 3 * D, "R2 low-power width", w, 3 * D);
    chk((r >= 1) && (r <= D + 1), "R7 low-power rise bound", r, D + 1);
    quiesce();
  endtask

  task automatic t_sir(input int P, input int lead);
    int r, w;
    sir_en = 1; sir_lp = 0;
    launch(0);
    observe(lead + 4 * P + 4, P, lead, -1, -1, r, w);
    chk(r == lead + 1, "R7 rise after baud tick", r, lead + 1);
    chk(w == 3 * P, "R4 baud16 width", w, 3 * P);
    quiesce();
  endtask

  task automatic t_ones();
    int r, w;
    sir_en = 1; sir_lp = 0;
    launch(1);
    observe(80, 8, 2, -1, -1, r, w);
    chk(r < 0, "R5 one bit normal mode", r, -1);
    quiesce();
    write_div(4);
    sir_en = 1; sir_lp = 1;
    launch(1);
    observe(80, 0, 0, -1, -1, r, w);
    chk(r < 0, "R5 one bit low-power mode", r, -1);
    quiesce();
  endtask

  task automatic t_disabled();
    int r, w;
    write_div(2);
    sir_en = 0; sir_lp = 1;
    launch(0);
    observe(80, 0, 0, -1, -1, r, w);
    chk(r < 0, "R6 disabled low-power", r, -1);
    sir_lp = 0;
    launch(0);
    observe(80, 4, 1, -1, -1, r, w);
    chk(r < 0, "R6 disabled normal", r, -1);
    quiesce();
  endtask

  task automatic t_div_change();
    int r, w;
    write_div(4);
    sir_en = 1; sir_lp = 1;
    launch(0);
    observe(80, 0, 0, 6, -1, r, w);
    cur_div = 6;
    chk(w == 4 + 2 * 6, "R8 width across divisor change", w, 16);
    quiesce();
    idle(20);
    sir_en = 1; sir_lp = 1;
    launch(0);
    observe(80, 0, 0, -1, -1, r, w);
    chk(w == 18, "R8 new divisor in force", w, 18);
    quiesce();
  endtask

  task automatic t_abort();
    int r, w;
    sir_en = 1; sir_lp = 0;
    launch(0);
    observe(60, 8, 2, -1, 5, r, w);
    chk(w == 6, "R9 pulse cut by disable", w, 6);
    @(negedge clk);
    sir_en = 1;
    observe(60, 8, 1, -1, -1, r, w);
    chk(r < 0, "R9 no pulse after re-enable", r, -1);
    quiesce();
  endtask

  initial begin
    t_reset();
    t_zero_div();
    t_lp(1);
    t_lp(5);
    t_lp(255);
    t_sir(16, 3);
    t_sir(4, 1);
    t_ones();
    t_disabled();
    t_div_change();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule